// File: doc/BRIEF.md
# Sleep and Protection Mode Controller

This block is the supervisory state machine that sits above a stepper motor driver's step sequencer and its current chopper. It watches one digital sleep level, the three step-mode select inputs, a protection-disable input and one overcurrent comparator per phase. From these it decides whether the power stage may drive, whether the sequencer must hold its position, and whether step edges may reach the sequencer yet.

There are two low-power states on the shared sleep level. In light sleep the power stage is off but the sequencer keeps following incoming steps, so a host can position the starting point before waking the motor. In deep sleep the sequencer is frozen as well, and every input except the sleep level is ignored. After either sleep state ends, a programmable hold-off masks step edges until the power stage has had time to recover. A filtered overcurrent trip sets a fault latch that turns the stage off. Only a power-on reset clears it.

Top module: `drive_supervisor`

## Requirements
- R1: After power-on reset (`rst_n` low), the block is running: `out_en`=1, `seq_freeze`=0, `fault`=0 and `ready`=1, with no hold-off pending.
- R2: While running, a high `sleep_lvl` enters light sleep at the next clock edge. In light sleep `out_en`=0, `seq_freeze`=0 and `ready`=0, and `step_out` follows `step_in`.
- R3: In light sleep, a low `sleep_lvl` with `mode_sel` not equal to 3'b111 returns the block to running (`out_en`=1) at the next edge.
- R4: In light sleep, a low `sleep_lvl` with `mode_sel`=3'b111 enters deep sleep at the next edge. Deep sleep gives `seq_freeze`=1, `out_en`=0 and `step_out`=0.
- R5: In deep sleep, changes on `mode_sel` and pulses on `logic_rst` have no effect. Only a high `sleep_lvl` leaves deep sleep, and it returns the block to running at the next edge.
- R6: After leaving deep sleep, a `sleep_lvl` that stays high does not re-enter light sleep. Light sleep is armed again only once `sleep_lvl` has been seen low.
- R7: Each exit from light or deep sleep to running starts a hold-off. For exactly `WAKE_CYCLES` clock cycles after the exit edge, `ready`=0 and `step_out`=0 even while `step_in`=1.
- R8: With `prot_dis`=0, when one overcurrent input `oc_in[p]` is high on `OC_FILT` consecutive clock edges, `fault` rises at the last of those edges, and `out_en` and `ready` go low. Shorter runs do not trip.
- R9: With `prot_dis`=1, `oc_in` is ignored: `fault` stays 0 however long an input stays high.
- R10: Once set, `fault` stays 1 through `logic_rst` pulses and after `oc_in` returns low. Only `rst_n` clears it.
- R11: Outside deep sleep, `logic_rst` forces the running state at the next edge and cancels any pending hold-off, so `ready`=1 at once. This holds even when the same cycle would otherwise have entered deep sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; the only way to clear the fault |
| logic_rst | input | 1 | Ordinary logic reset, active high, ignored in deep sleep |
| sleep_lvl | input | 1 | Digital sleep level taken from the reference pin |
| mode_sel | input | 3 | Step-mode select inputs; 3'b111 arms deep sleep |
| prot_dis | input | 1 | 1 disables overcurrent protection, 0 enables it |
| oc_in | input | PHASES | Overcurrent comparator output per phase, high when tripped |
| step_in | input | 1 | Step edge pulse from the host |
| step_out | output | 1 | Step edge pulse passed to the sequencer |
| out_en | output | 1 | Global power-stage enable |
| seq_freeze | output | 1 | Holds the sequencer state (deep sleep) |
| fault | output | 1 | Latched protection fault |
| ready | output | 1 | Running, no fault, hold-off elapsed: first step may be sent |

## Verification
The light-sleep exit is tried with all eight `mode_sel` values. Only 3'b111 may lead into deep sleep, and every other value must come back to running with an exact hold-off count. On the deep-sleep path, mode changes and logic resets are applied to separate the ignored inputs from the single exit condition. Then the level is held high afterwards to separate a level-triggered re-entry from the armed one. The protection path is swept over both phases, both values of `prot_dis` and run lengths from one cycle up to one cycle beyond the filter length. This separates the tripping edge from the edge before it, and a disabled trip from an enabled one. Each trip is followed by a logic reset to show that the latch holds.

// File: rtl/drive_sup_pkg.sv
// Shared types of the drive supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package drive_sup_pkg;

    // Supervisory operating state.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LIGHT = 2'd1,
        ST_DEEP  = 2'd2
    } sup_state_e;

endpackage

// File: rtl/sup_mode_fsm.sv
// Run / light-sleep / deep-sleep state machine.
// Emits a one-cycle wake event when a sleep state is left by its own exit
// condition. A logic reset that forces the running state raises no wake event.
// Assumes: rst_eff is logic_rst already qualified by "not in deep sleep".
module sup_mode_fsm
    import drive_sup_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_eff,
    input  logic              sleep_lvl,
    input  logic [MODE_W-1:0] mode_sel,
    output sup_state_e        state_o,
    output logic              wake_evt
);

    localparam logic [MODE_W-1:0] DEEP_CODE = '1;

    sup_state_e st_q, st_nxt;
    logic       hold_hi_q, hold_hi_nxt;
    logic       deep_armed;

    assign deep_armed = (mode_sel == DEEP_CODE);

    // Next-state decision from the current state and the sleep level.
    always_comb begin
        st_nxt      = st_q;
        hold_hi_nxt = hold_hi_q;
        case (st_q)
            ST_RUN: begin
                if (sleep_lvl && !hold_hi_q) st_nxt = ST_LIGHT;
            end
            ST_LIGHT: begin
                if (!sleep_lvl) st_nxt = deep_armed ? ST_DEEP : ST_RUN;
            end
            ST_DEEP: begin
                if (sleep_lvl) begin
                    st_nxt      = ST_RUN;
                    hold_hi_nxt = 1'b1;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
        if (!sleep_lvl) hold_hi_nxt = 1'b0;
        if (rst_eff) begin
            st_nxt      = ST_RUN;
            hold_hi_nxt = 1'b0;
        end
    end

    // Natural exit from either sleep state into running.
    assign wake_evt = (st_q != ST_RUN) && (st_nxt == ST_RUN) && !rst_eff;

    // State and re-entry guard registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_RUN;
            hold_hi_q <= 1'b0;
        end else begin
            st_q      <= st_nxt;
            hold_hi_q <= hold_hi_nxt;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/sup_wake_timer.sv
// Hold-off down-counter started by a wake event.
// busy stays high for exactly WAKE_CYCLES cycles after the loading edge.
// Assumes: WAKE_CYCLES >= 1; clear has priority over load.
module sup_wake_timer #(
    parameter int WAKE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    output logic busy
);

    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on wake, count down to zero, clear on logic reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/sup_fault_latch.sv
// Per-phase overcurrent run-length filter feeding one sticky fault latch.
// A phase trips when its input is high on OC_FILT consecutive edges while
// protection is enabled. The latch is cleared only by rst_n.
// Assumes: OC_FILT >= 1; oc_in is already synchronous to clk.
module sup_fault_latch #(
    parameter int PHASES  = 2,
    parameter int OC_FILT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic [PHASES-1:0] oc_in,
    output logic              fault
);

    localparam int FW = $clog2(OC_FILT + 1);
    localparam logic [FW-1:0] LAST = FW'(OC_FILT - 1);

    logic [PHASES-1:0] trip;
    logic              fault_q;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        logic [FW-1:0] run_q;
        logic          hit;

        assign hit     = prot_en && oc_in[p];
        assign trip[p] = hit && (run_q == LAST);

        // Count consecutive asserted cycles, restart on any gap.
        always_ff @(posedge clk) begin
            if (!rst_n || !hit) begin
                run_q <= '0;
            end else if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Sticky latch: set by any phase trip, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (|trip) begin
            fault_q <= 1'b1;
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/drive_supervisor.sv
// Supervisory controller above the step sequencer and chopper.
// Combines the sleep state machine, the wake hold-off timer and the fault
// latch into the power-stage enable, the sequencer freeze, the step gate
// and the ready indication.
// Assumes: all inputs synchronous to clk; rst_n is the power-on reset.
module drive_supervisor
    import drive_sup_pkg::*;
#(
    parameter int MODE_W      = 3,
    parameter int PHASES      = 2,
    parameter int WAKE_CYCLES = 5000,
    parameter int OC_FILT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              logic_rst,
    input  logic              sleep_lvl,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              prot_dis,
    input  logic [PHASES-1:0] oc_in,
    input  logic              step_in,
    output logic              step_out,
    output logic              out_en,
    output logic              seq_freeze,
    output logic              fault,
    output logic              ready
);

    sup_state_e state;
    logic       rst_eff;
    logic       wake_evt;
    logic       holdoff;
    logic       fault_w;

    // Logic reset is one of the inputs ignored in deep sleep.
    assign rst_eff = logic_rst && (state != ST_DEEP);

    sup_mode_fsm #(
        .MODE_W   (MODE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_eff  (rst_eff),
        .sleep_lvl(sleep_lvl),
        .mode_sel (mode_sel),
        .state_o  (state),
        .wake_evt (wake_evt)
    );

    sup_wake_timer #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(rst_eff),
        .load (wake_evt),
        .busy (holdoff)
    );

    sup_fault_latch #(
        .PHASES (PHASES),
        .OC_FILT(OC_FILT)
    ) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .prot_en(!prot_dis),
        .oc_in  (oc_in),
        .fault  (fault_w)
    );

    // Output decode from state, hold-off and fault.
    always_comb begin
        out_en     = (state == ST_RUN) && !fault_w;
        seq_freeze = (state == ST_DEEP);
        ready      = (state == ST_RUN) && !holdoff && !fault_w;
        step_out   = step_in && (state != ST_DEEP) && !holdoff;
        fault      = fault_w;
    end

endmodule

// File: rtl/drive_supervisor_chk.sv
// Port-level property checker for drive_supervisor, attached by bind.
// Assumes: WAKE_CYCLES >= 1.
module drive_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_lvl,
    input logic prot_dis,
    input logic step_in,
    input logic step_out,
    input logic out_en,
    input logic seq_freeze,
    input logic fault,
    input logic ready
);

    a_r8_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!out_en && !ready));

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    a_r9_disabled_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_dis && !fault) |=> !fault);

    a_r4_deep_off: assert property (@(posedge clk) disable iff (!rst_n)
        seq_freeze |-> (!out_en && !step_out && !ready));

    a_r5_deep_exit_level: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_freeze && !sleep_lvl) |=> seq_freeze);

    a_r7_no_ready_after_deep: assert property (@(posedge clk) disable iff (!rst_n)
        seq_freeze |=> (seq_freeze || !ready));

    a_r2_light_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !seq_freeze) |-> !ready);

    a_r7_step_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> step_in);

endmodule

bind drive_supervisor drive_supervisor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_lvl (sleep_lvl),
    .prot_dis  (prot_dis),
    .step_in   (step_in),
    .step_out  (step_out),
    .out_en    (out_en),
    .seq_freeze(seq_freeze),
    .fault     (fault),
    .ready     (ready)
);

// File: tb/drive_supervisor_test.sv
`timescale 1ns/1ps
module drive_supervisor_test;

    localparam int WAKE = 20;
    localparam int FILT = 3;
    localparam int PH   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          logic_rst = 1'b0;
    logic          sleep_lvl = 1'b0;
    logic [2:0]    mode_sel = 3'b000;
    logic          prot_dis = 1'b0;
    logic [PH-1:0] oc_in = '0;
    logic          step_in = 1'b0;
    logic          step_out, out_en, seq_freeze, fault, ready;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    drive_supervisor #(
        .MODE_W(3), .PHASES(PH), .WAKE_CYCLES(WAKE), .OC_FILT(FILT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .logic_rst(logic_rst), .sleep_lvl(sleep_lvl),
        .mode_sel(mode_sel), .prot_dis(prot_dis), .oc_in(oc_in),
        .step_in(step_in), .step_out(step_out), .out_en(out_en),
        .seq_freeze(seq_freeze), .fault(fault), .ready(ready)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_reset();
        rst_n = 1'b0; logic_rst = 1'b0; sleep_lvl = 1'b0; mode_sel = 3'b000;
        oc_in = '0; step_in = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Counts samples with ready low after a wake edge; checks step masking.
    task automatic measure_holdoff(input string req);
        int n = 0;
        step_in = 1'b1; #1;
        check(req, "step masked in hold-off", step_out, 0);
        while (!ready && n < 1000) begin
            n++;
            tick(1);
        end
        #1;
        check(req, "step passes after hold-off", step_out, 1);
        step_in = 1'b0;
        check(req, "hold-off length", n, WAKE);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog all: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(1);
        power_reset();
        // R1 reset state
        check("R1", "out_en", out_en, 1);
        check("R1", "seq_freeze", seq_freeze, 0);
        check("R1", "fault", fault, 0);
        check("R1", "ready", ready, 1);

        // Sweep of mode select at light-sleep exit
        for (int m = 0; m < 8; m++) begin
            sleep_lvl = 1'b1;
            tick(1);
            check("R2", "light out_en", out_en, 0);
            check("R2", "light freeze", seq_freeze, 0);
            check("R2", "light ready", ready, 0);
            step_in = 1'b1; #1;
            check("R2", "light step passes", step_out, 1);
            step_in = 1'b0;
            mode_sel = 3'(m);
            sleep_lvl = 1'b0;
            tick(1);
            if (m == 7) begin
                check("R4", "deep freeze", seq_freeze, 1);
                check("R4", "deep out_en", out_en, 0);
                step_in = 1'b1; #1;
                check("R4", "deep step masked", step_out, 0);
                step_in = 1'b0;
                mode_sel = 3'b000; tick(1);
                logic_rst = 1'b1; tick(1);
                logic_rst = 1'b0; tick(1);
                check("R5", "deep ignores mode and logic reset", seq_freeze, 1);
                sleep_lvl = 1'b1;
                tick(1);
                check("R5", "deep exit freeze", seq_freeze, 0);
                check("R5", "deep exit out_en", out_en, 1);
                measure_holdoff("R7");
                tick(3);
                check("R6", "no light re-entry while high", out_en, 1);
                sleep_lvl = 1'b0;
                tick(1);
                check("R6", "running after level low", out_en, 1);
                sleep_lvl = 1'b1;
                tick(1);
                check("R6", "light re-armed", out_en, 0);
                sleep_lvl = 1'b0;
                mode_sel = 3'b000;
                tick(1);
                measure_holdoff("R7");
            end else begin
                check("R3", "light exit out_en", out_en, 1);
                check("R3", "light exit freeze", seq_freeze, 0);
                measure_holdoff("R7");
            end
        end

        // R11 logic reset from light sleep beats a deep-sleep entry
        sleep_lvl = 1'b1; tick(1);
        mode_sel = 3'b111; sleep_lvl = 1'b0; logic_rst = 1'b1;
        tick(1);
        logic_rst = 1'b0;
        check("R11", "freeze after logic reset", seq_freeze, 0);
        check("R11", "ready immediately", ready, 1);
        mode_sel = 3'b000;

        // R11 logic reset cancels a pending hold-off
        sleep_lvl = 1'b1; tick(1);
        sleep_lvl = 1'b0; tick(1);
        check("R7", "hold-off started", ready, 0);
        logic_rst = 1'b1; tick(1);
        logic_rst = 1'b0;
        check("R11", "hold-off cancelled", ready, 1);

        // Protection sweep: disable, phase, run length
        for (int dis = 0; dis < 2; dis++) begin
            for (int ph = 0; ph < PH; ph++) begin
                for (int len = 1; len <= FILT + 1; len++) begin
                    power_reset();
                    check("R10", "fault cleared by power reset", fault, 0);
                    prot_dis = dis[0];
                    for (int i = 1; i <= len; i++) begin
                        oc_in[ph] = 1'b1;
                        tick(1);
                        check(dis ? "R9" : "R8", "fault during run", fault,
                              (dis == 0 && i >= FILT) ? 1 : 0);
                    end
                    oc_in = '0;
                    tick(1);
                    if (dis == 0 && len >= FILT) begin
                        check("R8", "out_en off", out_en, 0);
                        check("R8", "ready off", ready, 0);
                        logic_rst = 1'b1; tick(1);
                        logic_rst = 1'b0; tick(1);
                        check("R10", "fault held after logic reset", fault, 1);
                        check("R10", "out_en held off", out_en, 0);
                    end else begin
                        check(dis ? "R9" : "R8", "no trip", fault, 0);
                        check(dis ? "R9" : "R8", "out_en on", out_en, 1);
                    end
                    prot_dis = 1'b0;
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule